// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a multi-function peripheral controller, reached over a simple synchronous byte-wide I/O bus. Two neighbouring I/O addresses carry all traffic. The lower one is the index/key port and the upper one is the data port. While the block is locked, the only thing that has any effect is a key sequence written to the index port. Once the block is unlocked, a byte written to the index port selects a configuration register, and the data port reads or writes that register.

One index value holds the logical device number. This number decides which per-device register bank is reached by the upper index range. The lower index range reaches a global bank that every device shares. One write of the exit key locks the block again. The device number keeps its value until a hardware reset.

Software follows a fixed pattern. It writes the enter key twice, writes the device number through index 0x07, selects a register and accesses it through the data port. It then writes the exit key.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is locked, the index and the device number are 0x00, and every implemented register reads 0x00.
- R2: Two back-to-back writes of 0x87 to the index port (0x2E) unlock the block.
- R3: The key detector returns to its idle state in two cases: a byte other than 0x87 is written to the index port after the first key byte, or any other access (a read, or an access to another address) comes before the second key byte.
- R4: While unlocked, a write of 0xAA to the index port locks the block and leaves the index unchanged.
- R5: While unlocked, a write of any other byte to the index port loads it into the index, and a read of the index port returns the index. Each unlock clears the index to 0x00.
- R6: While locked, a write to the data port (0x2F) changes no register, and reads of either port return 0xFF.
- R7: Index 0x07 is the device number register. Its full byte is written and read through the data port, and it keeps its value across lock/unlock cycles.
- R8: Indices 0x20–0x2F are 16 global registers. These are the same for every device number.
- R9: Indices 0x30–0x3F are 16 registers for each of devices 0–7, and the device number selects the set. When the device number is 8 or above, this range reads 0x00 and ignores writes.
- R10: All other indices read 0x00, and writes to them are discarded.
- R11: The read data register updates at the clock edge that samples a read strobe and holds its value otherwise. A read of any address other than the two ports returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle, and that each strobe lasts one cycle with its address and data held steady. Under that assumption, every strobe counts as exactly one access to the key detector and to the register file. The stimulus follows this rule. It issues one access at a time and separates accesses with an idle cycle. Addresses, key bytes, index values and device numbers are drawn at random, but biased toward the two ports, the key values and the implemented ranges.

// File: rtl/keyed_cfg_port_pkg.sv
package keyed_cfg_port_pkg;

   // Lock state of the key detector
   typedef enum logic [1:0] {
      KEY_IDLE = 2'd0,
      KEY_HALF = 2'd1,
      KEY_OPEN = 2'd2
   } key_state_e;

   // Bit width needed to index a bank of the given size (at least one bit)
   function automatic int unsigned bank_off_w(input int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/keyed_cfg_port_key.sv
module keyed_cfg_port_key
   import keyed_cfg_port_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned KEY_ENTER = 'h87,
   parameter int unsigned KEY_EXIT  = 'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic              any_acc,
   input  logic [DATA_W-1:0] wdata,
   output logic              open,
   output logic              open_pulse
);

   localparam logic [DATA_W-1:0] ENTER_V = DATA_W'(KEY_ENTER);
   localparam logic [DATA_W-1:0] EXIT_V  = DATA_W'(KEY_EXIT);

   key_state_e state_q, state_d;

   logic is_enter;
   logic is_exit;

   assign is_enter = idx_wr && (wdata == ENTER_V);
   assign is_exit  = idx_wr && (wdata == EXIT_V);

   always_comb begin
      state_d    = state_q;
      open_pulse = 1'b0;
      unique case (state_q)
         KEY_IDLE: begin
            if (is_enter) state_d = KEY_HALF;
         end
         KEY_HALF: begin
            if (is_enter) begin
               state_d    = KEY_OPEN;
               open_pulse = 1'b1;
            end else if (any_acc) begin
               state_d = KEY_IDLE;
            end
         end
         KEY_OPEN: begin
            if (is_exit) state_d = KEY_IDLE;
         end
         default: state_d = KEY_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KEY_IDLE;
      else        state_q <= state_d;
   end

   assign open = (state_q == KEY_OPEN);

endmodule

// File: rtl/keyed_cfg_port_bank.sv
module keyed_cfg_port_bank
   import keyed_cfg_port_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned BASE   = 'h30,
   parameter int unsigned COUNT  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_val
);

   localparam int unsigned OFF_W = bank_off_w(COUNT);

   if (COUNT == 0) begin : g_bad_count
      $error("keyed_cfg_port_bank: COUNT must be at least 1");
   end
   if (BASE + COUNT > (1 << IDX_W)) begin : g_bad_range
      $error("keyed_cfg_port_bank: bank exceeds index space");
   end

   logic [DATA_W-1:0] regs_q [COUNT];
   logic [IDX_W-1:0]  rel;
   logic              hit;
   logic [OFF_W-1:0]  off;

   assign rel = idx - IDX_W'(BASE);
   assign hit = (idx >= IDX_W'(BASE)) && (rel < IDX_W'(COUNT));

   if (OFF_W < IDX_W) begin : g_off_trunc
      assign off = rel[OFF_W-1:0];
   end else begin : g_off_full
      assign off = OFF_W'(rel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(COUNT); i++) regs_q[i] <= '0;
      end else if (wr_en && hit) begin
         regs_q[off] <= wdata;
      end
   end

   assign rd_val = hit ? regs_q[off] : '0;

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import keyed_cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BASE_ADDR = 'h2E,
   parameter int unsigned KEY_ENTER = 'h87,
   parameter int unsigned KEY_EXIT  = 'hAA,
   parameter int unsigned LDN_INDEX = 'h07,
   parameter int unsigned GLB_BASE  = 'h20,
   parameter int unsigned GLB_REGS  = 16,
   parameter int unsigned DEV_BASE  = 'h30,
   parameter int unsigned DEV_REGS  = 16,
   parameter int unsigned NUM_DEV   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata
);

   localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR + 1);
   localparam logic [DATA_W-1:0] EXIT_V   = DATA_W'(KEY_EXIT);
   localparam logic [DATA_W-1:0] LDN_V    = DATA_W'(LDN_INDEX);
   localparam logic [DATA_W-1:0] IDLE_V   = '1;

   // Elaboration-time parameter checks
   if ((64'(BASE_ADDR) + 64'd1) >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("keyed_cfg_port: port pair does not fit the address width");
   end
   if (KEY_ENTER == KEY_EXIT) begin : g_bad_keys
      $error("keyed_cfg_port: enter and exit keys must differ");
   end
   if (LDN_INDEX >= GLB_BASE) begin : g_bad_ldn
      $error("keyed_cfg_port: device number index must lie below the global bank");
   end
   if (GLB_BASE + GLB_REGS > DEV_BASE) begin : g_bad_glb
      $error("keyed_cfg_port: global bank overlaps the device range");
   end
   if (NUM_DEV == 0) begin : g_bad_ndev
      $error("keyed_cfg_port: at least one logical device is required");
   end

   logic              idx_hit, dat_hit;
   logic              idx_wr, any_acc;
   logic              cfg_open, open_pulse;
   logic              dat_wr_open;
   logic [DATA_W-1:0] cfg_index;
   logic [DATA_W-1:0] cfg_ldn;
   logic [DATA_W-1:0] glb_rd;
   logic [DATA_W-1:0] dev_rd [NUM_DEV];
   logic [DATA_W-1:0] dev_sel;
   logic [DATA_W-1:0] reg_val;
   logic [DATA_W-1:0] rdata_d;

   assign idx_hit     = (io_addr == IDX_ADDR);
   assign dat_hit     = (io_addr == DAT_ADDR);
   assign idx_wr      = io_wr && idx_hit;
   assign any_acc     = io_wr || io_rd;
   assign dat_wr_open = cfg_open && io_wr && dat_hit;

   keyed_cfg_port_key #(
      .DATA_W   (DATA_W),
      .KEY_ENTER(KEY_ENTER),
      .KEY_EXIT (KEY_EXIT)
   ) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (idx_wr),
      .any_acc   (any_acc),
      .wdata     (io_wdata),
      .open      (cfg_open),
      .open_pulse(open_pulse)
   );

   // Index register: cleared on each unlock, loaded by non-exit index writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     cfg_index <= '0;
      else if (open_pulse)                            cfg_index <= '0;
      else if (cfg_open && idx_wr && io_wdata != EXIT_V) cfg_index <= io_wdata;
   end

   // Device number register: survives lock cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cfg_ldn <= '0;
      else if (dat_wr_open && cfg_index == LDN_V) cfg_ldn <= io_wdata;
   end

   keyed_cfg_port_bank #(
      .DATA_W(DATA_W),
      .IDX_W (DATA_W),
      .BASE  (GLB_BASE),
      .COUNT (GLB_REGS)
   ) u_glb (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dat_wr_open),
      .idx   (cfg_index),
      .wdata (io_wdata),
      .rd_val(glb_rd)
   );

   for (genvar g = 0; g < int'(NUM_DEV); g++) begin : g_dev
      logic dev_wr;
      assign dev_wr = dat_wr_open && (cfg_ldn == DATA_W'(g));
      keyed_cfg_port_bank #(
         .DATA_W(DATA_W),
         .IDX_W (DATA_W),
         .BASE  (DEV_BASE),
         .COUNT (DEV_REGS)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (dev_wr),
         .idx   (cfg_index),
         .wdata (io_wdata),
         .rd_val(dev_rd[g])
      );
   end

   always_comb begin
      dev_sel = '0;
      for (int d = 0; d < int'(NUM_DEV); d++) begin
         if (cfg_ldn == DATA_W'(d)) dev_sel = dev_rd[d];
      end
   end

   assign reg_val = (cfg_index == LDN_V) ? cfg_ldn : (glb_rd | dev_sel);

   always_comb begin
      rdata_d = IDLE_V;
      if (cfg_open) begin
         if (idx_hit)      rdata_d = cfg_index;
         else if (dat_hit) rdata_d = reg_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     io_rdata <= IDLE_V;
      else if (io_rd) io_rdata <= rdata_d;
   end

endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BASE_ADDR = 'h2E,
   parameter int unsigned KEY_ENTER = 'h87,
   parameter int unsigned KEY_EXIT  = 'hAA
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              cfg_open,
   input logic [DATA_W-1:0] cfg_index,
   input logic [DATA_W-1:0] cfg_ldn
);

   localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_ADDR + 1);
   localparam logic [DATA_W-1:0] ENT_V = DATA_W'(KEY_ENTER);
   localparam logic [DATA_W-1:0] EXT_V = DATA_W'(KEY_EXIT);
   localparam logic [DATA_W-1:0] FF_V  = '1;

   assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_A && io_wdata == ENT_V));

   assert_exit_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_wr && io_addr == IDX_A && io_wdata == EXT_V) |=> !cfg_open);

   assert_unlock_clears_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> (cfg_index == '0));

   assert_index_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_wr && io_addr == IDX_A && io_wdata != EXT_V)
      |=> (cfg_index == $past(io_wdata)));

   assert_locked_read_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && io_rd && (io_addr == DAT_A || io_addr == IDX_A)) |=> (io_rdata == FF_V));

   assert_ldn_kept_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(cfg_ldn));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata));

   assert_foreign_read_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr != IDX_A && io_addr != DAT_A) |=> (io_rdata == FF_V));

endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .BASE_ADDR(BASE_ADDR),
   .KEY_ENTER(KEY_ENTER),
   .KEY_EXIT (KEY_EXIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_addr  (io_addr),
   .io_wr    (io_wr),
   .io_rd    (io_rd),
   .io_wdata (io_wdata),
   .io_rdata (io_rdata),
   .cfg_open (cfg_open),
   .cfg_index(cfg_index),
   .cfg_ldn  (cfg_ldn)
);

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] A_IDX = 16'h002E;
   localparam logic [15:0] A_DAT = 16'h002F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;

   int n_checks = 0;
   int n_fail   = 0;

   // Reference model
   int         m_state = 0;   // 0 idle, 1 half key, 2 open
   logic [7:0] m_index = '0;
   logic [7:0] m_ldn   = '0;
   logic [7:0] m_glb [16];
   logic [7:0] m_dev [8][16];

   keyed_cfg_port u_keyed_cfg_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .io_wdata(io_wdata),
      .io_rdata(io_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] reg_value(input logic [7:0] idx);
      if (idx == 8'h07) return m_ldn;
      if (idx >= 8'h20 && idx <= 8'h2F) return m_glb[idx - 8'h20];
      if (idx >= 8'h30 && idx <= 8'h3F && m_ldn < 8) return m_dev[m_ldn[2:0]][idx - 8'h30];
      return 8'h00;
   endfunction

   function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
      if (a == A_IDX) begin
         case (m_state)
            0: if (d == 8'h87) m_state = 1;
            1: if (d == 8'h87) begin m_state = 2; m_index = 8'h00; end else m_state = 0;
            default: if (d == 8'hAA) m_state = 0; else m_index = d;
         endcase
      end else if (a == A_DAT && m_state == 2) begin
         if (m_index == 8'h07) m_ldn = d;
         else if (m_index >= 8'h20 && m_index <= 8'h2F) m_glb[m_index - 8'h20] = d;
         else if (m_index >= 8'h30 && m_index <= 8'h3F && m_ldn < 8)
            m_dev[m_ldn[2:0]][m_index - 8'h30] = d;
      end else if (m_state == 1) begin
         m_state = 0;
      end
   endfunction

   function automatic logic [7:0] model_read(input logic [15:0] a);
      logic [7:0] v;
      v = 8'hFF;
      if (m_state == 2) begin
         if (a == A_IDX) v = m_index;
         else if (a == A_DAT) v = reg_value(m_index);
      end
      if (m_state == 1) m_state = 0;
      return v;
   endfunction

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [15:0] a, input string req);
      logic [7:0] e;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      e = model_read(a);
      check(io_rdata, e, req);
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
      bus_write(A_IDX, idx);
      bus_write(A_DAT, d);
   endtask

   task automatic reg_read(input logic [7:0] idx, input logic [7:0] exp, input string req);
      bus_write(A_IDX, idx);
      bus_read(A_DAT, req);
      check(io_rdata, exp, req);
   endtask

   task automatic unlock();
      bus_write(A_IDX, 8'hAA);
      bus_write(A_IDX, 8'h87);
      bus_write(A_IDX, 8'h87);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'h5EED_2E2F));
      for (int i = 0; i < 16; i++) m_glb[i] = '0;
      for (int d = 0; d < 8; d++) for (int i = 0; i < 16; i++) m_dev[d][i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R6: reset state is locked
      check(io_rdata, 8'hFF, "R1 reset rdata");
      bus_read(A_DAT, "R6 locked data read");
      bus_read(A_IDX, "R6 locked index read");
      bus_write(A_DAT, 8'h55);

      // R2 / R5: unlock, index starts at zero
      bus_write(A_IDX, 8'h87);
      bus_write(A_IDX, 8'h87);
      bus_read(A_IDX, "R5 index after unlock");
      check(io_rdata, 8'h00, "R5 index cleared");
      reg_read(8'h00, 8'h00, "R10 index 0 reads zero");
      reg_read(8'h07, 8'h00, "R1 device number reset");
      reg_read(8'h25, 8'h00, "R1 global reg reset");

      // R7 / R9 / R8: device banks and shared global bank
      reg_write(8'h07, 8'h03);
      reg_read(8'h07, 8'h03, "R7 device number readback");
      reg_write(8'h35, 8'h5A);
      reg_read(8'h35, 8'h5A, "R9 device 3 reg");
      reg_write(8'h22, 8'hA5);
      reg_write(8'h07, 8'h04);
      reg_read(8'h35, 8'h00, "R9 device 4 separate");
      reg_read(8'h22, 8'hA5, "R8 global shared");
      reg_write(8'h07, 8'h0A);
      reg_write(8'h30, 8'h77);
      reg_read(8'h30, 8'h00, "R9 device out of range");
      reg_write(8'h07, 8'h00);
      reg_read(8'h30, 8'h00, "R9 write to absent device dropped");

      // R10: unimplemented indices
      reg_write(8'h10, 8'h66);
      reg_read(8'h10, 8'h00, "R10 unimplemented low");
      reg_write(8'h80, 8'h66);
      reg_read(8'h80, 8'h00, "R10 unimplemented high");

      // R4 / R6 / R7: relock, ignored write, persistence
      reg_write(8'h07, 8'h06);
      bus_write(A_IDX, 8'h3C);
      bus_write(A_IDX, 8'hAA);
      bus_read(A_DAT, "R4 locked after exit");
      check(io_rdata, 8'hFF, "R4 exit key locks");
      bus_write(A_DAT, 8'h99);
      bus_write(A_IDX, 8'h87);
      bus_write(A_IDX, 8'h87);
      bus_read(A_IDX, "R5 index cleared on relock");
      check(io_rdata, 8'h00, "R5 index zero after second unlock");
      reg_read(8'h07, 8'h06, "R7 device number kept");
      reg_read(8'h3C, 8'h00, "R6 locked data write ignored");

      // R3: interrupted key sequences
      bus_write(A_IDX, 8'hAA);
      bus_write(A_IDX, 8'h87);
      bus_write(A_IDX, 8'h55);
      bus_write(A_IDX, 8'h87);
      bus_read(A_DAT, "R3 wrong byte restarts");
      check(io_rdata, 8'hFF, "R3 still locked after wrong byte");
      bus_write(A_IDX, 8'h87);
      bus_read(16'h0060, "R11 foreign read");
      check(io_rdata, 8'hFF, "R11 foreign read FF");
      bus_write(A_IDX, 8'h87);
      bus_read(A_DAT, "R3 foreign access restarts");
      check(io_rdata, 8'hFF, "R3 still locked after foreign access");
      bus_write(A_IDX, 8'h87);
      bus_write(A_DAT, 8'h12);
      bus_write(A_IDX, 8'h87);
      bus_read(A_IDX, "R3 data write restarts");

      // R11: read data holds between reads
      unlock();
      bus_write(A_IDX, 8'h2B);
      bus_read(A_IDX, "R11 index read");
      held = io_rdata;
      repeat (4) @(negedge clk);
      check(io_rdata, held, "R11 rdata holds");

      // Constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         logic [7:0]  v;
         r = $urandom % 10;
         if (r < 4) begin
            case ($urandom % 8)
               0, 1:    v = 8'h87;
               2:       v = (($urandom % 4) == 0) ? 8'hAA : 8'h07;
               3:       v = 8'h07;
               4, 5:    v = 8'h20 + 8'($urandom % 32);
               6:       v = 8'h30 + 8'($urandom % 16);
               default: v = 8'($urandom);
            endcase
            bus_write(A_IDX, v);
         end else if (r < 6) begin
            v = (m_index == 8'h07) ? 8'($urandom % 10) : 8'($urandom);
            bus_write(A_DAT, v);
         end else if (r < 9) begin
            bus_read(A_DAT, "R9 random data read");
         end else if (($urandom % 2) == 0) begin
            bus_read(A_IDX, "R5 random index read");
         end else begin
            bus_read(16'($urandom), "R11 random address read");
         end
      end

      // Final sweep of every device bank and the global bank
      unlock();
      for (int d = 0; d < 8; d++) begin
         reg_write(8'h07, 8'(d));
         for (int i = 0; i < 16; i++)
            reg_read(8'h30 + 8'(i), m_dev[d][i], "R9 sweep device reg");
      end
      for (int i = 0; i < 16; i++)
         reg_read(8'h20 + 8'(i), m_glb[i], "R8 sweep global reg");

      finish_run();
   end

endmodule